// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write a 64K x 4 asynchronous static RAM. On the host side it uses a request/acknowledge handshake. The host holds `req_valid` high with a stable address, write flag and write nibble until it sees `req_ack` for one cycle. Read data comes back on `rsp_rdata` in the same cycle as the acknowledge.

On the memory side the controller drives the address bus, two active-low selects, an active-low write strobe and an active-low output enable. It also drives a 4-bit data-out bus with its own tristate enable. The shared data pad sits outside this block.

A write holds both selects and the write strobe low together for a pulse long enough to cover three things: the pulse width, the data setup and the select-to-end time. Output enable stays high for the whole write. The write strobe rises to end the write while the selects stay low for one more cycle, and the data drive is released only after that cycle.

A read holds the selects and output enable low for a set number of access clocks and samples the data on the last of them. Successive accesses are spaced by at least a minimum cycle time, counted from the start of the previous access.

Top module: `asram_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following cycle shows both selects, `mem_we_n` and `mem_oe_n` high, and `mem_dq_oe` and `req_ack` low.
- R2: A write holds both selects and `mem_we_n` low for exactly PULSE_CYC consecutive cycles. PULSE_CYC is the largest of WR_PULSE, DSETUP and SEL_SETUP. `mem_oe_n` stays high throughout.
- R3: During a write, `mem_dq_oe` is high with the write nibble on `mem_dq_out` from the first pulse cycle. It stays high in the cycle after `mem_we_n` rises, with the selects still low, and is low in the cycle after that.
- R4: `mem_addr` holds the request address and does not change while the selects are low.
- R5: A read holds both selects and `mem_oe_n` low for exactly ACCESS consecutive cycles, with `mem_we_n` high and `mem_dq_oe` low.
- R6: `rsp_rdata` presents the value that `mem_dq_in` carried in the last read-access cycle, and it is valid in the `req_ack` cycle.
- R7: `req_ack` is high for exactly one cycle per request. With no stall, it is seen PULSE_CYC+1 cycles after a write request is raised and ACCESS+1 cycles after a read request is raised.
- R8: Two access starts (select falling) are at least CYC_MIN cycles apart. A request raised immediately after the previous acknowledge starts exactly CYC_MIN cycles after the previous start.
- R9: Whenever the selects are high, `mem_we_n` and `mem_oe_n` are high and `mem_dq_oe` is low.
- R10: `mem_sel1_n` and `mem_sel2_n` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 4 | Write nibble |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read data, valid with `req_ack` |
| mem_addr | output | 16 | Memory address bus |
| mem_sel1_n | output | 1 | First active-low select |
| mem_sel2_n | output | 1 | Second active-low select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 4 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tristate enable for `mem_dq_out` |
| mem_dq_in | input | 4 | Data returned from the memory |

## Verification
The bench's memory model returns the inverted value on every read-access cycle except the last. A controller that samples one clock early therefore returns wrong read data.

The bench measures the write-strobe low time, the read-access length and the release of the data drive. A design that drops the drive in the same cycle the strobe rises, or that shortens the pulse below the data setup, shows up as a wrong count.

Back-to-back requests check that a start is stalled to exactly the minimum cycle spacing, not more and not less. The bench also watches that the two selects never diverge and that the write strobe and output enable are never active together.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
// Shared types for the asynchronous SRAM controller.
// Holds the sequencer state, the memory strobe bundle and two
// constant helper functions used to size the timing counters.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WR_PULSE  = 3'd1,
        ST_WR_HOLD   = 3'd2,
        ST_RD_ACCESS = 3'd3,
        ST_RD_DONE   = 3'd4
    } ctrl_state_e;

    typedef struct packed {
        logic sel_n;
        logic we_n;
        logic oe_n;
        logic drive;
        logic ack;
    } strobe_t;

    // Largest of three cycle counts: pulse must satisfy every write limit.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    // Strobe levels that belong to each sequencer state.
    function automatic strobe_t strobes_for(input ctrl_state_e s);
        strobe_t v;
        v.sel_n = 1'b1;
        v.we_n  = 1'b1;
        v.oe_n  = 1'b1;
        v.drive = 1'b0;
        v.ack   = 1'b0;
        case (s)
            ST_WR_PULSE: begin
                v.sel_n = 1'b0;
                v.we_n  = 1'b0;
                v.drive = 1'b1;
            end
            ST_WR_HOLD: begin
                v.sel_n = 1'b0;
                v.drive = 1'b1;
                v.ack   = 1'b1;
            end
            ST_RD_ACCESS: begin
                v.sel_n = 1'b0;
                v.oe_n  = 1'b0;
            end
            ST_RD_DONE: begin
                v.ack = 1'b1;
            end
            default: ;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/asram_cycle_timer.sv
`timescale 1ns/1ps
// Minimum cycle timer.
// Counts clocks since the last access start and reports when at
// least CYC_MIN clocks have passed. Assumes CYC_MIN >= 2.
// Comes out of reset already satisfied.
module asram_cycle_timer #(
    parameter int CYC_MIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);
    localparam int CW = $clog2(CYC_MIN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(CYC_MIN);

    logic [CW-1:0] elapsed_q;

    // Restart on an access start, otherwise count up and saturate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= LIMIT;
        end else if (start) begin
            elapsed_q <= CW'(1);
        end else if (elapsed_q < LIMIT) begin
            elapsed_q <= elapsed_q + CW'(1);
        end
    end

    assign ready = (elapsed_q >= LIMIT);
endmodule

// File: rtl/asram_phase_cnt.sv
`timescale 1ns/1ps
// Phase length counter.
// Loaded with (length - 1) when a phase is entered. It counts down and
// flags the final cycle of the phase. Assumes MAX_LEN >= 1.
module asram_phase_cnt #(
    parameter int MAX_LEN = 5,
    localparam int PW = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    output logic          last
);
    logic [PW-1:0] remain_q;

    // Load at phase entry, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - PW'(1);
        end
    end

    assign last = (remain_q == '0);
endmodule

// File: rtl/asram_dq_path.sv
`timescale 1ns/1ps
// Data path toward the memory.
// Holds the write nibble and the registered tristate enable. It captures
// read data on the last access clock. Assumes the sequencer gives the
// next-cycle drive level so that the enable comes from a flop.
module asram_dq_path #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_wr,
    input  logic [DW-1:0] wdata_in,
    input  logic          drive_next,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          drive_q;

    // Latch the write nibble when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (load_wr) begin
            wdata_q <= wdata_in;
        end
    end

    // Register the tristate enable so it never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
        end else begin
            drive_q <= drive_next;
        end
    end

    // Sample memory data at the end of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= dq_in;
        end
    end

    assign dq_out = wdata_q;
    assign dq_oe  = drive_q;
    assign rdata  = rdata_q;
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
// Asynchronous SRAM interface controller (top).
// Accepts one host request at a time and turns it into a strobe
// sequence for an asynchronous 64K x 4 SRAM. All strobes are registered.
// Write: select and write strobe low for PULSE_CYC clocks, then one hold
// clock with the write strobe high and the data still driven.
// Read: select and output enable low for ACCESS clocks, with data
// sampled on the last of them.
// Assumes the host keeps the request stable until the acknowledge.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 4,
    parameter int CYC_MIN   = 8,
    parameter int WR_PULSE  = 4,
    parameter int DSETUP    = 3,
    parameter int SEL_SETUP = 4,
    parameter int ACCESS    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_sel1_n,
    output logic          mem_sel2_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int PULSE_CYC = max3(WR_PULSE, DSETUP, SEL_SETUP);
    localparam int PHASE_MAX = (PULSE_CYC > ACCESS) ? PULSE_CYC : ACCESS;
    localparam int PW        = $clog2(PHASE_MAX + 1);

    ctrl_state_e   state_q, state_d;
    strobe_t       strb_q, strb_d;
    logic          timer_ready;
    logic          accept;
    logic          phase_last;
    logic          capture;
    logic [PW-1:0] phase_init;
    logic [AW-1:0] addr_q;

    asram_cycle_timer #(.CYC_MIN(CYC_MIN)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .ready (timer_ready)
    );

    asram_phase_cnt #(.MAX_LEN(PHASE_MAX)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (phase_init),
        .last     (phase_last)
    );

    asram_dq_path #(.DW(DW)) u_dq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_wr    (accept),
        .wdata_in   (req_wdata),
        .drive_next (strb_d.drive),
        .capture    (capture),
        .dq_in      (mem_dq_in),
        .dq_out     (mem_dq_out),
        .dq_oe      (mem_dq_oe),
        .rdata      (rsp_rdata)
    );

    // Phase length chosen from the request kind at acceptance.
    always_comb begin
        phase_init = req_write ? PW'(PULSE_CYC - 1) : PW'(ACCESS - 1);
    end

    // Sequencer next state, acceptance and read capture.
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        capture = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid && timer_ready) begin
                    accept  = 1'b1;
                    state_d = req_write ? ST_WR_PULSE : ST_RD_ACCESS;
                end
            end
            ST_WR_PULSE: begin
                if (phase_last) state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
            end
            ST_RD_ACCESS: begin
                if (phase_last) begin
                    capture = 1'b1;
                    state_d = ST_RD_DONE;
                end
            end
            ST_RD_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        strb_d = strobes_for(state_d);
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Strobe register: outputs come straight from flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_q <= strobes_for(ST_IDLE);
        end else begin
            strb_q <= strb_d;
        end
    end

    // Address register, loaded only when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_sel1_n = strb_q.sel_n;
    assign mem_sel2_n = strb_q.sel_n;
    assign mem_we_n   = strb_q.we_n;
    assign mem_oe_n   = strb_q.oe_n;
    assign req_ack    = strb_q.ack;
endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for asram_ctrl, attached with bind.
// Measures strobe windows and access spacing at the ports with its
// own counters.
module asram_ctrl_chk #(
    parameter int AW        = 16,
    parameter int CYC_MIN   = 8,
    parameter int PULSE_CYC = 4,
    parameter int DSETUP    = 3,
    parameter int ACCESS    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_sel1_n,
    input logic          mem_sel2_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_dq_oe,
    input logic          req_ack,
    input logic [AW-1:0] mem_addr
);
    logic [7:0]  we_low_cnt;
    logic [7:0]  rd_cnt;
    logic [15:0] gap_cnt;
    logic        sel_prev;

    // Count write-strobe-low cycles, read-window cycles and start spacing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            rd_cnt     <= '0;
            gap_cnt    <= 16'(CYC_MIN);
            sel_prev   <= 1'b1;
        end else begin
            we_low_cnt <= !mem_we_n ? ((we_low_cnt == 8'hff) ? we_low_cnt : we_low_cnt + 8'd1) : 8'd0;
            rd_cnt     <= (!mem_sel1_n && !mem_oe_n) ? ((rd_cnt == 8'hff) ? rd_cnt : rd_cnt + 8'd1) : 8'd0;
            if (!mem_sel1_n && sel_prev) gap_cnt <= 16'd1;
            else if (gap_cnt != 16'hffff) gap_cnt <= gap_cnt + 16'd1;
            sel_prev <= mem_sel1_n;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mem_sel1_n && mem_sel2_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ack));

    a_r2_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_sel1_n && mem_dq_oe));

    a_r2_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt == 8'(PULSE_CYC) && we_low_cnt >= 8'(DSETUP)));

    a_r3_hold_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_sel1_n));

    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> !mem_dq_oe);

    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel1_n && $past(!mem_sel1_n)) |-> $stable(mem_addr));

    a_r5_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_dq_oe && !mem_sel1_n));

    a_r5_access_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (rd_cnt == 8'(ACCESS)));

    a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    a_r8_min_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_sel1_n) |-> (gap_cnt >= 16'(CYC_MIN)));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel1_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

    a_r10_sel_match: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel1_n == mem_sel2_n);
endmodule

bind asram_ctrl asram_ctrl_chk #(
    .AW        (AW),
    .CYC_MIN   (CYC_MIN),
    .PULSE_CYC (PULSE_CYC),
    .DSETUP    (DSETUP),
    .ACCESS    (ACCESS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_sel1_n (mem_sel1_n),
    .mem_sel2_n (mem_sel2_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_oe  (mem_dq_oe),
    .req_ack    (req_ack),
    .mem_addr   (mem_addr)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;
    localparam int CYC_MIN   = 8;
    localparam int PULSE_CYC = 4;
    localparam int ACCESS    = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ack;
    logic [3:0]  rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_sel1_n, mem_sel2_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [3:0]  mem_dq_out;
    logic [3:0]  mem_dq_in = 4'ha;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_gap = 0;
    int last_start = 0;
    bit have_start = 0;
    int wr_len = 0;
    int rd_len = 0;
    bit rel_pending = 0;
    bit prev_sel = 1'b1;
    bit prev_we = 1'b1;
    bit prev_ack = 1'b0;
    logic [15:0] start_addr = '0;
    logic [15:0] pend_addr = '0;
    logic [3:0]  pend_data = '0;
    logic [3:0]  model_mem [int];
    logic [3:0]  ref_mem [int];

    always #2 clk = ~clk;

    asram_ctrl #(.CYC_MIN(CYC_MIN), .WR_PULSE(4), .DSETUP(3), .SEL_SETUP(4), .ACCESS(ACCESS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_sel1_n(mem_sel1_n), .mem_sel2_n(mem_sel2_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [3:0] model_read(input logic [15:0] a);
        return model_mem.exists(int'(a)) ? model_mem[int'(a)] : 4'h0;
    endfunction

    function automatic logic [3:0] ref_read(input logic [15:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 4'h0;
    endfunction

    // Port monitor and memory model, evaluated away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(mem_sel1_n == mem_sel2_n, "R10 selects equal", mem_sel2_n, mem_sel1_n);
            if (!mem_sel1_n && prev_sel) begin
                if (have_start) begin
                    last_gap = cyc - last_start;
                    check(last_gap >= CYC_MIN, "R8 start spacing", last_gap, CYC_MIN);
                end
                have_start = 1;
                last_start = cyc;
                start_addr = mem_addr;
            end
            if (!mem_sel1_n) check(mem_addr == start_addr, "R4 address stable", mem_addr, start_addr);
            if (!mem_we_n) begin
                wr_len++;
                check(mem_oe_n && mem_dq_oe && !mem_sel1_n, "R2 write strobes", {mem_oe_n, mem_dq_oe, mem_sel1_n}, 3'b110);
                pend_addr = mem_addr;
                pend_data = mem_dq_out;
            end
            if (mem_we_n && !prev_we) begin
                check(wr_len == PULSE_CYC, "R2 pulse length", wr_len, PULSE_CYC);
                check(mem_dq_oe && !mem_sel1_n, "R3 hold cycle drive", {mem_dq_oe, mem_sel1_n}, 2'b10);
                model_mem[int'(pend_addr)] = pend_data;
                rel_pending = 1;
                wr_len = 0;
            end else if (rel_pending) begin
                check(!mem_dq_oe, "R3 drive released", mem_dq_oe, 0);
                rel_pending = 0;
            end
            if (!mem_sel1_n && !mem_oe_n) begin
                rd_len++;
                check(mem_we_n && !mem_dq_oe, "R5 read strobes", {mem_we_n, mem_dq_oe}, 2'b10);
                mem_dq_in = (rd_len == ACCESS) ? model_read(mem_addr) : ~model_read(mem_addr);
            end else begin
                if (rd_len > 0) check(rd_len == ACCESS, "R5 access length", rd_len, ACCESS);
                rd_len = 0;
                mem_dq_in = 4'ha;
            end
            if (mem_sel1_n)
                check(mem_we_n && mem_oe_n && !mem_dq_oe, "R9 idle strobes", {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b110);
            if (req_ack && prev_ack) check(0, "R7 ack width", 2, 1);
        end
        prev_sel = mem_sel1_n;
        prev_we  = mem_we_n;
        prev_ack = req_ack;
    end

    task automatic do_op(input bit wr, input logic [15:0] a, input logic [3:0] d, input bit lat_known);
        int n;
        logic [3:0] exp;
        @(negedge clk);
        exp = ref_read(a);
        if (wr) ref_mem[int'(a)] = d;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!req_ack);
        req_valid = 1'b0;
        if (!wr) check(rsp_rdata == exp, "R6 read data", rsp_rdata, exp);
        if (lat_known)
            check(n == (wr ? PULSE_CYC + 1 : ACCESS + 1), "R7 ack latency", n, wr ? PULSE_CYC + 1 : ACCESS + 1);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (5) @(negedge clk);
        check(mem_sel1_n && mem_sel2_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ack,
              "R1 reset state", {mem_sel1_n, mem_sel2_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ack}, 6'b111100);
        rst_n = 1'b1;
        repeat (CYC_MIN) @(negedge clk);

        // Directed corners: address and data extremes, unwritten read.
        do_op(0, 16'h1234, 4'h0, 1);
        repeat (CYC_MIN) @(negedge clk);
        do_op(1, 16'h0000, 4'hf, 1);
        repeat (CYC_MIN) @(negedge clk);
        do_op(1, 16'hffff, 4'h5, 1);
        repeat (CYC_MIN) @(negedge clk);
        do_op(0, 16'h0000, 4'h0, 1);
        repeat (CYC_MIN) @(negedge clk);
        do_op(0, 16'hffff, 4'h0, 1);

        // Back-to-back: stall to exactly the minimum spacing (R8).
        do_op(1, 16'h00aa, 4'h3, 0);
        do_op(1, 16'h00ab, 4'hc, 0);
        check(last_gap == CYC_MIN, "R8 write-write stall", last_gap, CYC_MIN);
        do_op(0, 16'h00aa, 4'h0, 0);
        check(last_gap == CYC_MIN, "R8 write-read stall", last_gap, CYC_MIN);
        do_op(1, 16'h00aa, 4'h9, 0);
        check(last_gap == CYC_MIN, "R8 read-write stall", last_gap, CYC_MIN);
        do_op(0, 16'h00aa, 4'h0, 0);
        check(last_gap == CYC_MIN, "R8 write-read stall 2", last_gap, CYC_MIN);

        // Constrained random mix over a small address window.
        for (int i = 0; i < 400; i++) begin
            int idle;
            logic [15:0] a;
            idle = int'($urandom_range(0, 12));
            a = ($urandom_range(0, 7) == 0) ? 16'(16'hfff0 | 16'($urandom_range(0, 15))) : 16'($urandom_range(0, 31));
            repeat (idle) @(negedge clk);
            do_op(1'($urandom_range(0, 1)), a, 4'($urandom_range(0, 15)), idle >= CYC_MIN);
        end

        repeat (CYC_MIN) @(negedge clk);
        finish_run();
    end
endmodule